// File: doc/BRIEF.md
# Asynchronous Byte-Bus Register Front End for a Calendar Clock

This block is the host-facing side of a calendar clock. A processor reaches it over an 8-bit parallel bus. The bus has a three-bit address, an active-low chip select and separate active-low write and read strobes. Eight locations are decoded. Locations 0 to 6 hold the time and calendar bytes. Those bytes live in a counter outside this block, so a write to one of them is passed on as a one-cycle strobe carrying its address and byte. A read of one of them returns the matching byte of a flat vector that the counter supplies.

Location 7 combines a mode register with a command register. Bits 7:4 of a write always load the four-bit mode field. Bit 3 of the same write decides what bits 2:0 mean: clock commands or interval-pulse commands. A read of location 7 never returns what was written there. It returns the live busy, oscillator and pulse-pin flags.

Write address and data are latched by the rising edge of the write strobe. A toggle then carries the event into the reference clock domain through a two-flop synchronizer. The read path is combinational from the bus pins. The data bus is split into input, output and output-enable, so the chip-level pad can build the tri-state driver.

Top module: `rtc_bus_if`

## Requirements
- R1: After reset, mode_o is 0, clk_stop_o, int_stop_o and tp_enable_o are 0, no strobe output is high, and bus_doe is 0 while the bus is idle.
- R2: A rising edge of bus_wr_n while bus_cs_n is low, at an address 0 to 6, produces exactly one tw_pulse_o cycle, with tw_addr_o and tw_data_o equal to the bus address and byte present at that edge.
- R3: A rising edge of bus_wr_n while bus_cs_n is high has no effect. No strobe fires, and the mode and level outputs keep their values.
- R4: A write to address 7 loads data bits 7:4 into mode_o, whatever the value of bit 3.
- R5: A write to address 7 with bit 3 = 0 sets clk_stop_o to bit 0 and, when bit 1 is 1, fires clk_reset_o for one cycle. int_stop_o and tp_enable_o keep their values.
- R6: A write to address 7 with bit 3 = 1 sets int_stop_o to bit 1 and tp_enable_o to bit 2, and, when bit 0 is 1, fires int_reset_o for one cycle. clk_stop_o keeps its value.
- R7: While bus_doe is high at address a in 0 to 6, bus_dout equals bits 8a+7 to 8a of time_rd_i.
- R8: While bus_doe is high at address 7, bus_dout is {5'b0, tp_level_i, osc_ok_i, busy_i}. Bit 0 is busy, bit 1 is the oscillator flag, bit 2 is the pulse-pin state, and bit 3 and above read 0.
- R9: bus_doe is high exactly when bus_cs_n and bus_rd_n are both low.
- R10: clk_reset_o, int_reset_o and tw_pulse_o never stay high for two consecutive cycles. The mode and level outputs change only on a decoded write.
- R11: The outputs that a write affects change on the third rising edge of clk after the rising edge of bus_wr_n. Successive write strobes must be at least four clk cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_wr_n | input | 1 | Write strobe; data is taken on its rising edge |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_addr | input | 3 | Register address |
| bus_din | input | 8 | Write data from the bus |
| bus_dout | output | 8 | Read data toward the bus |
| bus_doe | output | 1 | Pad output enable for bus_dout |
| time_rd_i | input | 56 | Time bytes 0 to 6 from the counter, byte a at bits 8a+7:8a |
| busy_i | input | 1 | Counter increment in progress |
| osc_ok_i | input | 1 | Oscillator running flag |
| tp_level_i | input | 1 | Present level of the pulse pin |
| tw_pulse_o | output | 1 | One-cycle strobe for a time byte write |
| tw_addr_o | output | 3 | Address for tw_pulse_o |
| tw_data_o | output | 8 | Data for tw_pulse_o |
| mode_o | output | 4 | Mode field for the pulse generator |
| clk_stop_o | output | 1 | Hold the seconds input of the counter |
| clk_reset_o | output | 1 | One-cycle reset of the sub-second prescaler |
| int_stop_o | output | 1 | Freeze the interval timer |
| int_reset_o | output | 1 | One-cycle restart of the interval timer |
| tp_enable_o | output | 1 | Enable the pulse output |

## Verification
On every cycle, the embedded properties check the following: each strobe lasts a single cycle; a time-byte strobe never coincides with a command strobe; the mode and level registers stay still when no decoded write occurs; and a pulse-side command leaves the clock-stop level alone. The bench scenarios are the only place that shows the following: the byte landing on the right output, a write with chip select high being dropped at the ports, the live status replacing the written value on reads of location 7, and the exact three-edge latency of a write.

// File: rtl/rtc_bus_pkg.sv
package rtc_bus_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int MODE_W    = 4;
  localparam int SEL_BIT   = 3;
  localparam int CTRL_ADDR = 7;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } bus_wr_t;
endpackage

// File: rtl/rtc_wr_capture.sv
module rtc_wr_capture
  import rtc_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              evt_o,
  output bus_wr_t           cap_o
);
  logic                   tog_q;
  bus_wr_t                cap_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   seen_q;

  // Capture in the strobe domain; only a selected chip sees the edge.
  always_ff @(posedge wr_n or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      cap_q <= '0;
    end else if (!cs_n) begin
      tog_q <= ~tog_q;
      cap_q <= '{addr: addr, data: din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      seen_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], tog_q};
      seen_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign evt_o = sync_q[SYNC_STAGES-1] ^ seen_q;
  assign cap_o = cap_q;

  p_evt_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o);
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_bus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  bus_wr_t           cap_i,
  output logic              tw_pulse_o,
  output logic [ADDR_W-1:0] tw_addr_o,
  output logic [DATA_W-1:0] tw_data_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              clk_stop_o,
  output logic              clk_reset_o,
  output logic              int_stop_o,
  output logic              int_reset_o,
  output logic              tp_enable_o
);
  logic hit_ctl, hit_time, sel_tp;

  assign hit_ctl  = evt_i && (cap_i.addr == ADDR_W'(CTRL_ADDR));
  assign hit_time = evt_i && !hit_ctl;
  assign sel_tp   = cap_i.data[SEL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tw_pulse_o  <= 1'b0;
      tw_addr_o   <= '0;
      tw_data_o   <= '0;
      mode_o      <= '0;
      clk_stop_o  <= 1'b0;
      clk_reset_o <= 1'b0;
      int_stop_o  <= 1'b0;
      int_reset_o <= 1'b0;
      tp_enable_o <= 1'b0;
    end else begin
      tw_pulse_o  <= hit_time;
      clk_reset_o <= 1'b0;
      int_reset_o <= 1'b0;
      if (hit_time) begin
        tw_addr_o <= cap_i.addr;
        tw_data_o <= cap_i.data;
      end
      if (hit_ctl) begin
        mode_o <= cap_i.data[DATA_W-1 -: MODE_W];
        if (sel_tp) begin
          int_reset_o <= cap_i.data[0];
          int_stop_o  <= cap_i.data[1];
          tp_enable_o <= cap_i.data[2];
        end else begin
          clk_stop_o  <= cap_i.data[0];
          clk_reset_o <= cap_i.data[1];
        end
      end
    end
  end

  p_levels_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_i |=> ($stable(mode_o) && $stable(clk_stop_o) && $stable(int_stop_o)
                && $stable(tp_enable_o)));
  p_clkrst_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_reset_o |=> !clk_reset_o);
  p_intrst_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int_reset_o |=> !int_reset_o);
  p_tp_keeps_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ctl && sel_tp) |=> $stable(clk_stop_o));
  p_time_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tw_pulse_o |-> (!clk_reset_o && !int_reset_o));
endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
  import rtc_bus_pkg::*;
#(
  parameter int NUM_TIME = (1 << ADDR_W) - 1
) (
  input  logic                       cs_n,
  input  logic                       rd_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NUM_TIME*DATA_W-1:0] time_rd_i,
  input  logic                       busy_i,
  input  logic                       osc_ok_i,
  input  logic                       tp_level_i,
  output logic [DATA_W-1:0]          dout,
  output logic                       doe
);
  logic [DATA_W-1:0] bytes [NUM_TIME];
  logic [DATA_W-1:0] status;

  for (genvar g = 0; g < NUM_TIME; g++) begin : g_byte
    assign bytes[g] = time_rd_i[g*DATA_W +: DATA_W];
  end

  assign status = {{(DATA_W-3){1'b0}}, tp_level_i, osc_ok_i, busy_i};

  always_comb begin
    if (addr == ADDR_W'(CTRL_ADDR)) dout = status;
    else                            dout = bytes[addr];
  end

  assign doe = !cs_n && !rd_n;
endmodule

// File: rtl/rtc_bus_if.sv
module rtc_bus_if
  import rtc_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  localparam int NUM_TIME   = (1 << ADDR_W) - 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_cs_n,
  input  logic                       bus_wr_n,
  input  logic                       bus_rd_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_din,
  output logic [DATA_W-1:0]          bus_dout,
  output logic                       bus_doe,
  input  logic [NUM_TIME*DATA_W-1:0] time_rd_i,
  input  logic                       busy_i,
  input  logic                       osc_ok_i,
  input  logic                       tp_level_i,
  output logic                       tw_pulse_o,
  output logic [ADDR_W-1:0]          tw_addr_o,
  output logic [DATA_W-1:0]          tw_data_o,
  output logic [MODE_W-1:0]          mode_o,
  output logic                       clk_stop_o,
  output logic                       clk_reset_o,
  output logic                       int_stop_o,
  output logic                       int_reset_o,
  output logic                       tp_enable_o
);
  logic    evt;
  bus_wr_t cap;

  rtc_wr_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst_n(rst_n), .wr_n(bus_wr_n), .cs_n(bus_cs_n),
    .addr(bus_addr), .din(bus_din), .evt_o(evt), .cap_o(cap)
  );

  rtc_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .cap_i(cap),
    .tw_pulse_o(tw_pulse_o), .tw_addr_o(tw_addr_o), .tw_data_o(tw_data_o),
    .mode_o(mode_o), .clk_stop_o(clk_stop_o), .clk_reset_o(clk_reset_o),
    .int_stop_o(int_stop_o), .int_reset_o(int_reset_o),
    .tp_enable_o(tp_enable_o)
  );

  rtc_read_mux #(.NUM_TIME(NUM_TIME)) u_rd (
    .cs_n(bus_cs_n), .rd_n(bus_rd_n), .addr(bus_addr), .time_rd_i(time_rd_i),
    .busy_i(busy_i), .osc_ok_i(osc_ok_i), .tp_level_i(tp_level_i),
    .dout(bus_dout), .doe(bus_doe)
  );
endmodule

// File: tb/rtc_bus_if_bench.sv
module rtc_bus_if_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [2:0]  addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        doe;
  logic [55:0] time_rd = '0;
  logic        busy = 1'b0, osc = 1'b0, tp = 1'b0;
  logic        tw_pulse, clk_stop, clk_reset, int_stop, int_reset, tp_en;
  logic [2:0]  tw_addr;
  logic [7:0]  tw_data;
  logic [3:0]  mode;

  int checks = 0, errors = 0;
  int tw_cnt = 0, crst_cnt = 0, irst_cnt = 0;
  int e_tw = 0, e_crst = 0, e_irst = 0;
  logic [2:0] last_a = '0;
  logic [7:0] last_d = '0;
  logic [3:0] e_mode = '0;
  logic e_cstop = 0, e_istop = 0, e_tpen = 0;

  always #4 clk = ~clk;

  rtc_bus_if u_rtc_bus_if (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_wr_n(wr_n),
    .bus_rd_n(rd_n), .bus_addr(addr), .bus_din(din), .bus_dout(dout),
    .bus_doe(doe), .time_rd_i(time_rd), .busy_i(busy), .osc_ok_i(osc),
    .tp_level_i(tp), .tw_pulse_o(tw_pulse), .tw_addr_o(tw_addr),
    .tw_data_o(tw_data), .mode_o(mode), .clk_stop_o(clk_stop),
    .clk_reset_o(clk_reset), .int_stop_o(int_stop), .int_reset_o(int_reset),
    .tp_enable_o(tp_en)
  );

  always @(negedge clk) begin
    if (tw_pulse) begin tw_cnt <= tw_cnt + 1; last_a <= tw_addr; last_d <= tw_data; end
    if (clk_reset) crst_cnt <= crst_cnt + 1;
    if (int_reset) irst_cnt <= irst_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    if (a == 3'd7) return {5'b0, tp, osc, busy};
    return time_rd[a*8 +: 8];
  endfunction

  task automatic check_state();
    chk(mode == e_mode, "R4 mode", mode, e_mode);
    chk(clk_stop == e_cstop, "R5 clk_stop", clk_stop, e_cstop);
    chk(int_stop == e_istop, "R6 int_stop", int_stop, e_istop);
    chk(tp_en == e_tpen, "R6 tp_enable", tp_en, e_tpen);
    chk(tw_cnt == e_tw, "R2 tw strobe count", tw_cnt, e_tw);
    chk(crst_cnt == e_crst, "R5 R10 clk_reset count", crst_cnt, e_crst);
    chk(irst_cnt == e_irst, "R6 R10 int_reset count", irst_cnt, e_irst);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input bit sel);
    @(negedge clk);
    cs_n = !sel; addr = a; din = d;
    @(negedge clk); wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (sel && a != 3'd7)
      chk(tw_pulse == 1'b1, "R11 third-edge latency", tw_pulse, 1);
    if (!sel) begin
      chk(tw_pulse == 1'b0 && clk_reset == 1'b0 && int_reset == 1'b0,
          "R3 no strobe when deselected", tw_pulse, 0);
    end else if (a == 3'd7) begin
      e_mode = d[7:4];
      if (d[3]) begin
        e_istop = d[1]; e_tpen = d[2]; if (d[0]) e_irst++;
      end else begin
        e_cstop = d[0]; if (d[1]) e_crst++;
      end
    end else e_tw++;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    check_state();
    if (sel && a != 3'd7) begin
      chk(last_a == a, "R2 tw_addr", last_a, a);
      chk(last_d == d, "R2 tw_data", last_d, d);
    end
  endtask

  task automatic bus_read(input logic [2:0] a);
    @(negedge clk);
    cs_n = 1'b0; addr = a; rd_n = 1'b0;
    #1;
    chk(doe == 1'b1, "R9 doe on read", doe, 1);
    if (a == 3'd7) chk(dout == exp_read(a), "R8 status read", dout, exp_read(a));
    else           chk(dout == exp_read(a), "R7 time byte read", dout, exp_read(a));
    @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;
    #1;
    chk(doe == 1'b0, "R9 doe released", doe, 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(mode == 0 && clk_stop == 0 && int_stop == 0 && tp_en == 0, "R1 levels", mode, 0);
    chk(tw_pulse == 0 && clk_reset == 0 && int_reset == 0, "R1 strobes", tw_pulse, 0);
    chk(doe == 0, "R1 bus idle", doe, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9 partial selections
    cs_n = 1'b1; rd_n = 1'b0; #1;
    chk(doe == 0, "R9 deselected read", doe, 0);
    cs_n = 1'b0; rd_n = 1'b1; #1;
    chk(doe == 0, "R9 no read strobe", doe, 0);
    cs_n = 1'b1;

    // Directed corners
    bus_write(3'd3, 8'h59, 1'b1);            // R2
    bus_write(3'd7, 8'hA3, 1'b1);            // R4 R5: stop + reset pulse
    bus_write(3'd7, 8'h57, 1'b0);            // R3 ignored
    bus_write(3'd7, 8'h0F, 1'b1);            // R6: int reset, stop, tp enable
    bus_write(3'd7, 8'h08, 1'b1);            // R6 clear levels, clk_stop kept
    bus_write(3'd0, 8'hFF, 1'b0);            // R3 ignored
    bus_write(3'd7, 8'h30, 1'b1);            // R5 clear clk_stop
    time_rd = 56'h66_55_44_33_22_11_00;
    busy = 1'b1; osc = 1'b0; tp = 1'b1;
    bus_read(3'd7);                          // R8 live, not written value
    bus_read(3'd6);                          // R7

    // Constrained random mix
    for (int i = 0; i < 80; i++) begin
      if (($urandom % 4) != 0)
        bus_write(3'($urandom % 8), 8'($urandom), ($urandom % 5) != 0);
      else begin
        time_rd = {$urandom, 24'($urandom)};
        busy = 1'($urandom); osc = 1'($urandom); tp = 1'($urandom);
        bus_read(3'($urandom % 8));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule